// File: doc/BRIEF.md
# Block Reader for High-Capacity Memory Cards over SPI

This block brings a high-capacity memory card up in SPI mode on its own after reset and then serves single 512-byte block reads to a host, one byte at a time. It is aimed at hardware boot loaders that copy program images from a card into on-chip memory with no processor involved. It has no data buffer and no CRC logic. Every byte the host asks for is shifted out of the card at that moment, so the block is little more than a control state machine, a 24-byte command store and a byte-wide shift engine.

The host sees a single handshake for both jobs. `busy` is high while initialization, a command, a byte fetch or the end-of-block flush is under way. When `busy` falls, `err` holds the result of that job. A read opens on a rising edge of `blk_req`, which also latches the 32-bit block number. Each one-cycle `byte_req` pulse fetches the next byte onto `rd_data`. Lowering `blk_req` closes the read, whether or not all 512 bytes were taken. After any failure the block refuses further reads until it is reset.

Top module: `sdspi_block_reader`

## Requirements
- R1: While `rst` is high, `busy` is 1, `err` is 0, `spi_cs_n` is 1 and `spi_sclk` is 0. After `rst` falls, the block issues exactly 80 SPI clocks with `spi_cs_n` high before the first command byte.
- R2: While idle between bytes, `spi_sclk` rests at 0 and `spi_mosi` at 1. During initialization, the SPI clock period is 2*HALF_SLOW cycles of `clk`. Once initialization succeeds, it is 2*HALF_FAST cycles.
- R3: Commands go out in this order, identified by their first frame byte: 0x40, then 0x48, then pairs 0x77, 0x69. The pair repeats while the 0x69 command is answered with 0x01. An answer of 0x00 ends initialization: `busy` falls with `err` at 0.
- R4: Initialization fails in two cases. One is POLL_LIMIT consecutive 0xFF bytes while waiting for a response. The other is an unexpected response: anything but 0x01 to 0x40, or a last trailing byte other than 0xAA after 0x48. On failure, `busy` falls with `err` at 1.
- R5: In idle, a rising edge of `blk_req` raises `busy` on the next clock and latches `blk_addr`. The block then sends the frame 0x51, the address most significant byte first, then 0xFF. It waits for response 0x00 and then for data token 0xFE. When the token arrives, `busy` falls with `err` at 0.
- R6: During an open read, each `byte_req` pulse raises `busy` until the next block byte, in order from byte 0, is on `rd_data`. Once 512 bytes have been taken, further pulses leave `busy` low and `rd_data` unchanged.
- R7: Lowering `blk_req` during an open read raises `busy`. The block then clocks out the untaken data bytes and both CRC bytes without checking them, and `busy` falls with `err` at 0, leaving the card ready for the next command.
- R8: If a read receives POLL_LIMIT consecutive 0xFF bytes while awaiting its response or the data token, `busy` falls with `err` at 1. From then until reset, `blk_req` edges are ignored: `busy` stays 0, `err` stays 1 and `spi_sclk` does not toggle. A reset re-runs initialization and makes reads possible again.
- R9: `spi_cs_n` goes low with the first command and stays low until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; its release starts initialization |
| blk_req | input | 1 | Rising edge opens a block read; falling edge closes it |
| byte_req | input | 1 | One-cycle pulse fetching the next byte of the open block |
| blk_addr | input | 32 | Block number, latched when a read opens |
| rd_data | output | 8 | Last fetched block byte |
| busy | output | 1 | High while a job is in progress |
| err | output | 1 | Result of the last job, valid once `busy` is low |
| spi_sclk | output | 1 | SPI clock to the card, mode 0 |
| spi_cs_n | output | 1 | Card chip select, active low |
| spi_mosi | output | 1 | Serial data to the card |
| spi_miso | input | 1 | Serial data from the card |

## Verification
The bench builds the block with HALF_SLOW=4, HALF_FAST=1 and the default POLL_LIMIT of 255. A slow byte then takes about 70 cycles and a fast one about 20. This keeps complete initializations, several full and partial 512-byte reads, and full-length response timeouts, both at initialization and during a read, within a few tens of thousands of cycles. A card model in the bench answers each command frame from the wire, with adjustable gaps, a busy-loop count, a wrong CMD8 echo and silent modes. The bench can therefore observe the exact command order, the clock periods in both phases and whether the flush left the card's stream empty.

// File: rtl/sdr_pkg.sv
package sdr_pkg;

    localparam int BLK_BYTES   = 512;
    localparam int CRC_BYTES   = 2;
    localparam int FRAME_BYTES = 6;
    localparam int PRE_BYTES   = 10;
    localparam int CNT_W       = $clog2(BLK_BYTES + CRC_BYTES);
    localparam int POLL_W      = 16;
    localparam int DIV_W       = 16;

    localparam logic [7:0] FILL_BYTE  = 8'hFF;
    localparam logic [7:0] DATA_TOKEN = 8'hFE;
    localparam logic [7:0] RD_HEADER  = 8'h51;
    localparam logic [7:0] IFC_ECHO   = 8'hAA;

    typedef enum logic [3:0] {
        S_PWR, S_CMD, S_RESP, S_TAIL, S_TOKEN,
        S_READY, S_FETCH, S_DRAIN, S_IDLE, S_FAIL
    } rd_state_e;

    typedef enum logic [2:0] {
        C_GO  = 3'd0,
        C_IFC = 3'd1,
        C_APP = 3'd2,
        C_OPC = 3'd3,
        C_RD  = 3'd4
    } cmd_e;

    typedef struct packed {
        rd_state_e          st;
        cmd_e               cmd;
        logic [CNT_W-1:0]   cnt;
        logic [POLL_W-1:0]  poll;
        logic [31:0]        addr;
        logic [7:0]         data;
        logic               busy;
        logic               err;
        logic               cs_n;
        logic               fast;
        logic               start;
        logic               pend;
        logic               req_q;
        logic [7:0]         tx;
    } ctl_t;

    typedef struct packed {
        logic               act;
        logic               sclk;
        logic               fast;
        logic               done;
        logic [2:0]         bitn;
        logic [DIV_W-1:0]   div;
        logic [7:0]         txs;
        logic [7:0]         rxs;
    } xfer_t;

endpackage

// File: rtl/sdr_cmd_rom.sv
module sdr_cmd_rom (
    input  logic [4:0] idx,
    output logic [7:0] data
);
    always_comb begin
        case (idx)
            5'd0:  data = 8'h40;
            5'd1:  data = 8'h00;
            5'd2:  data = 8'h00;
            5'd3:  data = 8'h00;
            5'd4:  data = 8'h00;
            5'd5:  data = 8'h95;
            5'd6:  data = 8'h48;
            5'd7:  data = 8'h00;
            5'd8:  data = 8'h00;
            5'd9:  data = 8'h01;
            5'd10: data = 8'hAA;
            5'd11: data = 8'h87;
            5'd12: data = 8'h77;
            5'd13: data = 8'h00;
            5'd14: data = 8'h00;
            5'd15: data = 8'h00;
            5'd16: data = 8'h00;
            5'd17: data = 8'h65;
            5'd18: data = 8'h69;
            5'd19: data = 8'h40;
            5'd20: data = 8'h00;
            5'd21: data = 8'h00;
            5'd22: data = 8'h00;
            5'd23: data = 8'h77;
            default: data = 8'hFF;
        endcase
    end
endmodule

// File: rtl/sdr_spi_xfer.sv
module sdr_spi_xfer
    import sdr_pkg::*;
#(
    parameter int HALF_SLOW = 312,
    parameter int HALF_FAST = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       fast,
    input  logic [7:0] tx,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic       done,
    output logic [7:0] rx
);
    localparam logic [DIV_W-1:0] SLOW_M1 = DIV_W'(HALF_SLOW - 1);
    localparam logic [DIV_W-1:0] FAST_M1 = DIV_W'(HALF_FAST - 1);

    localparam xfer_t XF_RST = '{act: 1'b0, sclk: 1'b0, fast: 1'b0, done: 1'b0,
                                 bitn: '0, div: '0, txs: 8'hFF, rxs: 8'hFF};

    xfer_t r_q, r_d;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        if (!r_q.act) begin
            if (start) begin
                r_d.act  = 1'b1;
                r_d.fast = fast;
                r_d.txs  = tx;
                r_d.bitn = '0;
                r_d.sclk = 1'b0;
                r_d.div  = fast ? FAST_M1 : SLOW_M1;
            end
        end else if (r_q.div != '0) begin
            r_d.div = r_q.div - 1'b1;
        end else begin
            r_d.div = r_q.fast ? FAST_M1 : SLOW_M1;
            if (!r_q.sclk) begin
                r_d.sclk = 1'b1;
                r_d.rxs  = {r_q.rxs[6:0], miso};
            end else begin
                r_d.sclk = 1'b0;
                if (r_q.bitn == 3'd7) begin
                    r_d.act  = 1'b0;
                    r_d.done = 1'b1;
                end else begin
                    r_d.bitn = r_q.bitn + 1'b1;
                    r_d.txs  = {r_q.txs[6:0], 1'b1};
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= XF_RST;
        else     r_q <= r_d;
    end

    assign sclk = r_q.sclk;
    assign mosi = r_q.act ? r_q.txs[7] : 1'b1;
    assign done = r_q.done;
    assign rx   = r_q.rxs;

    // R2: lines rest between bytes
    p_lines_rest_r2: assert property (@(posedge clk) disable iff (rst)
        !r_q.act |-> (!sclk && mosi));
    // R2: completion is a single-cycle pulse
    p_done_single_r2: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

// File: rtl/sdspi_block_reader.sv
module sdspi_block_reader
    import sdr_pkg::*;
#(
    parameter int HALF_SLOW  = 312,
    parameter int HALF_FAST  = 1,
    parameter int POLL_LIMIT = 255
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        blk_req,
    input  logic        byte_req,
    input  logic [31:0] blk_addr,
    output logic [7:0]  rd_data,
    output logic        busy,
    output logic        err,
    output logic        spi_sclk,
    output logic        spi_cs_n,
    output logic        spi_mosi,
    input  logic        spi_miso
);
    localparam logic [POLL_W-1:0] POLL_LAST = POLL_W'(POLL_LIMIT - 1);
    localparam logic [CNT_W-1:0]  BLK_END   = CNT_W'(BLK_BYTES);
    localparam logic [CNT_W-1:0]  FLUSH_END = CNT_W'(BLK_BYTES + CRC_BYTES - 1);
    localparam logic [CNT_W-1:0]  PRE_LAST  = CNT_W'(PRE_BYTES - 1);
    localparam logic [CNT_W-1:0]  FRM_LAST  = CNT_W'(FRAME_BYTES - 1);
    localparam logic [CNT_W-1:0]  TAIL_LAST = CNT_W'(3);

    localparam ctl_t CTL_RST = '{st: S_PWR, cmd: C_GO, cnt: '0, poll: '0,
                                 addr: '0, data: '0, busy: 1'b1, err: 1'b0,
                                 cs_n: 1'b1, fast: 1'b0, start: 1'b0,
                                 pend: 1'b0, req_q: 1'b0, tx: FILL_BYTE};

    ctl_t        r_q, r_d;
    logic        x_done;
    logic [7:0]  x_rx;
    logic [4:0]  rom_idx;
    logic [7:0]  rom_byte;
    logic [7:0]  frame_byte;
    logic        needs_xfer;

    sdr_cmd_rom u_rom (
        .idx  (rom_idx),
        .data (rom_byte)
    );

    sdr_spi_xfer #(
        .HALF_SLOW (HALF_SLOW),
        .HALF_FAST (HALF_FAST)
    ) u_xfer (
        .clk   (clk),
        .rst   (rst),
        .start (r_q.start),
        .fast  (r_q.fast),
        .tx    (r_q.tx),
        .miso  (spi_miso),
        .sclk  (spi_sclk),
        .mosi  (spi_mosi),
        .done  (x_done),
        .rx    (x_rx)
    );

    assign rom_idx = 5'(r_q.cmd[1:0]) * 5'd6 + 5'(r_q.cnt[2:0]);

    always_comb begin
        if (r_q.cmd == C_RD) begin
            case (r_q.cnt[2:0])
                3'd0:    frame_byte = RD_HEADER;
                3'd1:    frame_byte = r_q.addr[31:24];
                3'd2:    frame_byte = r_q.addr[23:16];
                3'd3:    frame_byte = r_q.addr[15:8];
                3'd4:    frame_byte = r_q.addr[7:0];
                default: frame_byte = FILL_BYTE;
            endcase
        end else begin
            frame_byte = rom_byte;
        end
    end

    assign needs_xfer = (r_q.st == S_PWR)   || (r_q.st == S_CMD)   ||
                        (r_q.st == S_RESP)  || (r_q.st == S_TAIL)  ||
                        (r_q.st == S_TOKEN) || (r_q.st == S_FETCH) ||
                        (r_q.st == S_DRAIN);

    always_comb begin
        logic fail;
        fail      = 1'b0;
        r_d       = r_q;
        r_d.start = 1'b0;
        r_d.req_q = blk_req;

        if (needs_xfer && !r_q.pend) begin
            r_d.start = 1'b1;
            r_d.pend  = 1'b1;
            r_d.tx    = (r_q.st == S_CMD) ? frame_byte : FILL_BYTE;
        end

        if (x_done) begin
            r_d.pend = 1'b0;
            case (r_q.st)
                S_PWR: begin
                    if (r_q.cnt == PRE_LAST) begin
                        r_d.cs_n = 1'b0;
                        r_d.cnt  = '0;
                        r_d.cmd  = C_GO;
                        r_d.st   = S_CMD;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
                S_CMD: begin
                    if (r_q.cnt == FRM_LAST) begin
                        r_d.cnt  = '0;
                        r_d.poll = '0;
                        r_d.st   = S_RESP;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
                S_RESP: begin
                    if (x_rx == FILL_BYTE) begin
                        if (r_q.poll == POLL_LAST) fail = 1'b1;
                        else r_d.poll = r_q.poll + 1'b1;
                    end else begin
                        r_d.cnt = '0;
                        case (r_q.cmd)
                            C_GO: begin
                                if (x_rx == 8'h01) begin r_d.cmd = C_IFC; r_d.st = S_CMD; end
                                else fail = 1'b1;
                            end
                            C_IFC: begin
                                if (x_rx == 8'h01) r_d.st = S_TAIL;
                                else fail = 1'b1;
                            end
                            C_APP: begin
                                if (x_rx[7:1] == 7'd0) begin r_d.cmd = C_OPC; r_d.st = S_CMD; end
                                else fail = 1'b1;
                            end
                            C_OPC: begin
                                if (x_rx == 8'h00) begin
                                    r_d.st   = S_IDLE;
                                    r_d.busy = 1'b0;
                                    r_d.err  = 1'b0;
                                    r_d.fast = 1'b1;
                                end else if (x_rx == 8'h01) begin
                                    r_d.cmd = C_APP;
                                    r_d.st  = S_CMD;
                                end else begin
                                    fail = 1'b1;
                                end
                            end
                            default: begin
                                if (x_rx == 8'h00) begin r_d.poll = '0; r_d.st = S_TOKEN; end
                                else fail = 1'b1;
                            end
                        endcase
                    end
                end
                S_TAIL: begin
                    if (r_q.cnt == TAIL_LAST) begin
                        r_d.cnt = '0;
                        if (x_rx == IFC_ECHO) begin r_d.cmd = C_APP; r_d.st = S_CMD; end
                        else fail = 1'b1;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
                S_TOKEN: begin
                    if (x_rx == DATA_TOKEN) begin
                        r_d.cnt  = '0;
                        r_d.busy = 1'b0;
                        r_d.st   = S_READY;
                    end else if (x_rx == FILL_BYTE) begin
                        if (r_q.poll == POLL_LAST) fail = 1'b1;
                        else r_d.poll = r_q.poll + 1'b1;
                    end else begin
                        fail = 1'b1;
                    end
                end
                S_FETCH: begin
                    r_d.data = x_rx;
                    r_d.cnt  = r_q.cnt + 1'b1;
                    r_d.busy = 1'b0;
                    r_d.st   = S_READY;
                end
                S_DRAIN: begin
                    if (r_q.cnt == FLUSH_END) begin
                        r_d.st   = S_IDLE;
                        r_d.busy = 1'b0;
                        r_d.err  = 1'b0;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
                default: ;
            endcase
        end

        case (r_q.st)
            S_IDLE: begin
                if (blk_req && !r_q.req_q) begin
                    r_d.addr = blk_addr;
                    r_d.cmd  = C_RD;
                    r_d.cnt  = '0;
                    r_d.busy = 1'b1;
                    r_d.err  = 1'b0;
                    r_d.st   = S_CMD;
                end
            end
            S_READY: begin
                if (!blk_req) begin
                    r_d.busy = 1'b1;
                    r_d.st   = S_DRAIN;
                end else if (byte_req && r_q.cnt != BLK_END) begin
                    r_d.busy = 1'b1;
                    r_d.st   = S_FETCH;
                end
            end
            default: ;
        endcase

        if (fail) begin
            r_d.st   = S_FAIL;
            r_d.busy = 1'b0;
            r_d.err  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= CTL_RST;
        else     r_q <= r_d;
    end

    assign rd_data  = r_q.data;
    assign busy     = r_q.busy;
    assign err      = r_q.err;
    assign spi_cs_n = r_q.cs_n;

    // R4: a reported failure is never accompanied by busy
    p_err_not_busy_r4: assert property (@(posedge clk) disable iff (rst)
        err |-> !busy);
    // R6: a byte pulse on an open, unexhausted block raises busy next cycle
    p_fetch_busy_r6: assert property (@(posedge clk) disable iff (rst)
        (r_q.st == S_READY && blk_req && byte_req && r_q.cnt != BLK_END) |=> busy);
    // R7: flush keeps busy high
    p_flush_busy_r7: assert property (@(posedge clk) disable iff (rst)
        (r_q.st == S_DRAIN) |-> busy);
    // R8: failure is sticky until reset
    p_fail_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (r_q.st == S_FAIL) |=> (r_q.st == S_FAIL && err && !busy));
    // R8: no card clock after failure
    p_fail_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (r_q.st == S_FAIL) |-> !spi_sclk);
    // R9: chip select stays low once lowered
    p_cs_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        !spi_cs_n |=> !spi_cs_n);
endmodule

// File: tb/sdspi_block_reader_test.sv
module sdspi_block_reader_test;

    localparam int CLK_PERIOD = 10;
    localparam int HS = 4;
    localparam int HF = 1;

    typedef struct packed {
        logic [31:0] addr;
        logic [9:0]  take;
        logic [7:0]  tgap;
    } rd_vec_t;

    localparam rd_vec_t VEC [4] = '{
        '{32'h0000_0000, 10'd512, 8'd1},
        '{32'h0001_2345, 10'd3,   8'd40},
        '{32'hDEAD_BEEF, 10'd0,   8'd2},
        '{32'h7FFF_FFFF, 10'd20,  8'd5}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        blk_req = 1'b0;
    logic        byte_req = 1'b0;
    logic [31:0] blk_addr = '0;
    logic [7:0]  rd_data;
    logic        busy, err, spi_sclk, spi_cs_n, spi_mosi, spi_miso;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdspi_block_reader #(.HALF_SLOW(HS), .HALF_FAST(HF), .POLL_LIMIT(255)) uut (
        .clk(clk), .rst(rst), .blk_req(blk_req), .byte_req(byte_req),
        .blk_addr(blk_addr), .rd_data(rd_data), .busy(busy), .err(err),
        .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso)
    );

    // ---------------- card model ----------------
    logic [7:0]  fifo [0:2047];
    int          fh, ft;
    logic [7:0]  rx_sh, tx_sh;
    int          bitc;
    bit          load_pend;
    logic [7:0]  frame [0:5];
    int          fidx;
    bit          collecting;
    logic [7:0]  cmd_log [0:63];
    int          ncmd;
    logic [31:0] last_arg;
    int          pre_clks, sclk_rises, cyc, last_rise, last_period;
    int          acmd_cnt;
    bit          ready;
    bit          card_present, bad_echo, tok_silent;
    int          acmd_busy_n, tok_gap;

    assign spi_miso = tx_sh[7];

    always @(negedge clk) cyc = cyc + 1;

    function automatic logic [7:0] pat(input logic [31:0] a, input int i);
        return 8'((a * 13) + (i * 7) + (i >> 8));
    endfunction

    task automatic push(input logic [7:0] b);
        fifo[ft % 2048] = b;
        ft = ft + 1;
    endtask

    task automatic serve_cmd();
        int idx;
        if (ncmd < 64) cmd_log[ncmd] = frame[0];
        ncmd = ncmd + 1;
        idx = int'(frame[0] & 8'h3F);
        if (!card_present) return;
        push(8'hFF);
        case (idx)
            0: push(8'h01);
            8: begin
                push(8'h01); push(8'h00); push(8'h00); push(8'h01);
                push(bad_echo ? 8'h55 : 8'hAA);
            end
            55: push(ready ? 8'h00 : 8'h01);
            41: begin
                if (acmd_cnt < acmd_busy_n) begin push(8'h01); acmd_cnt++; end
                else begin push(8'h00); ready = 1; end
            end
            17: begin
                last_arg = {frame[1], frame[2], frame[3], frame[4]};
                push(8'h00);
                if (tok_silent) return;
                for (int k = 0; k < tok_gap; k++) push(8'hFF);
                push(8'hFE);
                for (int k = 0; k < 512; k++) push(pat(last_arg, k));
                push(8'h5A); push(8'hA5);
            end
            default: push(8'h04);
        endcase
    endtask

    task automatic take_byte(input logic [7:0] b);
        if (!collecting) begin
            if (b[7:6] == 2'b01) begin collecting = 1; frame[0] = b; fidx = 1; end
        end else begin
            frame[fidx] = b;
            fidx = fidx + 1;
            if (fidx == 6) begin collecting = 0; serve_cmd(); end
        end
    endtask

    always @(posedge spi_sclk) begin
        sclk_rises = sclk_rises + 1;
        last_period = cyc - last_rise;
        last_rise = cyc;
        if (spi_cs_n) begin
            if (ncmd == 0) pre_clks = pre_clks + 1;
            bitc = 0;
        end else begin
            rx_sh = {rx_sh[6:0], spi_mosi};
            bitc = bitc + 1;
            if (bitc == 8) begin
                bitc = 0;
                take_byte(rx_sh);
                load_pend = 1;
            end
        end
    end

    always @(negedge spi_sclk) begin
        if (load_pend) begin
            load_pend = 0;
            if (fh != ft) begin tx_sh = fifo[fh % 2048]; fh = fh + 1; end
            else tx_sh = 8'hFF;
        end else begin
            tx_sh = {tx_sh[6:0], 1'b1};
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic card_reset(input bit present, input bit bad8, input int acmd_n);
        fh = 0; ft = 0; bitc = 0; load_pend = 0; collecting = 0; fidx = 0;
        ncmd = 0; pre_clks = 0; acmd_cnt = 0; ready = 0; tx_sh = 8'hFF;
        rx_sh = 8'h00; last_arg = '0; sclk_rises = 0;
        card_present = present; bad_echo = bad8; acmd_busy_n = acmd_n;
        tok_silent = 0; tok_gap = 1;
    endtask

    task automatic do_reset(input bit present, input bit bad8, input int acmd_n);
        @(negedge clk);
        rst = 1; blk_req = 0; byte_req = 0;
        card_reset(present, bad8, acmd_n);
        repeat (4) @(negedge clk);
        rst = 0;
    endtask

    task automatic wait_free();
        while (busy) @(negedge clk);
    endtask

    task automatic open_read(input logic [31:0] a);
        @(negedge clk);
        blk_addr = a;
        blk_req = 1;
        @(negedge clk);
        chk(busy == 1'b1, "R5 busy after open", 32'(busy), 1);
        wait_free();
    endtask

    task automatic get_byte();
        @(negedge clk);
        byte_req = 1;
        @(negedge clk);
        byte_req = 0;
        wait_free();
    endtask

    task automatic close_read();
        @(negedge clk);
        blk_req = 0;
        @(negedge clk);
        chk(busy == 1'b1, "R7 busy during flush", 32'(busy), 1);
        wait_free();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails = fails + 1;
        $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int bad;
        int first_bad;
        logic [7:0] held;
        int n0, s0;

        cyc = 0; last_rise = 0; last_period = 0;
        card_reset(1, 0, 2);
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(busy == 1'b1 && err == 1'b0, "R1 reset busy/err", {30'd0, busy, err}, 32'h2);
        chk(spi_cs_n == 1'b1 && spi_sclk == 1'b0, "R1 reset lines",
            {30'd0, spi_cs_n, spi_sclk}, 32'h2);
        @(negedge clk);
        rst = 0;
        wait_free();

        // R1, R2, R3, R9: initialization
        chk(pre_clks == 80, "R1 preamble clocks", 32'(pre_clks), 80);
        chk(err == 1'b0, "R3 init result", 32'(err), 0);
        chk(last_period == 2*HS, "R2 init clock period", 32'(last_period), 2*HS);
        chk(ncmd == 8, "R3 command count", 32'(ncmd), 8);
        bad = 0;
        for (int k = 0; k < 8; k++) begin
            logic [7:0] e;
            e = (k == 0) ? 8'h40 : (k == 1) ? 8'h48 : (k % 2 == 0) ? 8'h77 : 8'h69;
            if (k < ncmd && cmd_log[k] != e) bad = bad + 1;
        end
        chk(bad == 0, "R3 command order", 32'(bad), 0);
        chk(spi_cs_n == 1'b0, "R9 select low after init", 32'(spi_cs_n), 0);

        // R5, R6, R7: table of reads
        foreach (VEC[v]) begin
            tok_gap = int'(VEC[v].tgap);
            open_read(VEC[v].addr);
            chk(err == 1'b0, "R5 read open result", 32'(err), 0);
            chk(last_arg == VEC[v].addr, "R5 address on wire", last_arg, VEC[v].addr);
            chk(cmd_log[(ncmd - 1) % 64] == 8'h51, "R5 read header",
                32'(cmd_log[(ncmd - 1) % 64]), 32'h51);
            bad = 0; first_bad = -1;
            for (int i = 0; i < int'(VEC[v].take); i++) begin
                get_byte();
                if (rd_data != pat(VEC[v].addr, i)) begin
                    bad = bad + 1;
                    if (first_bad < 0) first_bad = i;
                end
            end
            chk(bad == 0, "R6 byte stream", 32'(first_bad), 32'hFFFF_FFFF);
            if (v == 0) begin
                chk(last_period == 2*HF, "R2 fast clock period", 32'(last_period), 2*HF);
                held = rd_data;
                @(negedge clk); byte_req = 1;
                @(negedge clk); byte_req = 0;
                repeat (3) @(negedge clk);
                chk(busy == 1'b0 && rd_data == held, "R6 pulse past block end",
                    {23'd0, busy, rd_data}, {24'd0, held});
            end
            close_read();
            chk(err == 1'b0, "R7 flush result", 32'(err), 0);
            chk(fh == ft, "R7 card stream emptied", 32'(ft - fh), 0);
        end

        // R8: read timeout waiting for token, then refusal
        tok_silent = 1;
        open_read(32'h0000_0042);
        chk(err == 1'b1, "R8 read timeout err", 32'(err), 1);
        @(negedge clk); blk_req = 0;
        repeat (3) @(negedge clk);
        n0 = ncmd; s0 = sclk_rises;
        blk_req = 1;
        repeat (60) @(negedge clk);
        chk(busy == 1'b0 && err == 1'b1, "R8 refused after fail", {30'd0, busy, err}, 32'h1);
        chk(sclk_rises == s0 && ncmd == n0, "R8 no card traffic", 32'(sclk_rises - s0), 0);
        @(negedge clk); blk_req = 0;

        // R4: no card present
        do_reset(0, 0, 0);
        wait_free();
        chk(err == 1'b1, "R4 absent card err", 32'(err), 1);
        chk(ncmd == 1, "R4 only first command sent", 32'(ncmd), 1);

        // R4: wrong trailing echo after 0x48
        do_reset(1, 1, 0);
        wait_free();
        chk(err == 1'b1, "R4 bad echo err", 32'(err), 1);
        chk(ncmd == 2, "R4 stop after 0x48", 32'(ncmd), 2);

        // R8, R3: reset restores service; card ready at first 0x69
        do_reset(1, 0, 0);
        wait_free();
        chk(err == 1'b0 && ncmd == 4, "R3 init single pair", 32'(ncmd), 4);
        tok_gap = 3;
        open_read(32'h0000_0100);
        get_byte(); get_byte();
        chk(rd_data == pat(32'h100, 1), "R8 read after re-init", 32'(rd_data),
            32'(pat(32'h100, 1)));
        close_read();
        chk(fh == ft && err == 1'b0, "R7 flush after re-init", 32'(ft - fh), 0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule